// File: doc/BRIEF.md
# Multi-Domain Clock Ratio Controller

This block derives clock-enable strobes for three clock domains from a single master clock: the core together with the other bus masters, the on-chip peripherals, and the external bus. Each domain has a 3-bit ratio field that software writes through a small write port. A new value is held as pending and is applied only when the bus reports the end of its current cycle. While any applied field is nonzero the block reports multi-clock mode. Once all three applied fields are zero it reports normal mode.

Every strobe is a single-master-cycle pulse taken from one shared free-running counter, so the three domains stay phase-aligned. The peripheral and external-bus rates are clamped so that they never run faster than the core rate. The block also tracks low-power states. A sleep request enters a light sleep that stops only the core strobe, or a deep standby that stops every strobe. Interrupts wake the block from either state. A pin reset or a watchdog reset returns everything to normal mode.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows all applied and pending fields at zero, `mode_multi_o`=0, `lp_state_o`=0 and the shared counter at 0. In that state all three enables are high every cycle.
- R2: A write with `wr_en_i`=1 stores `wr_data_i` as the pending field picked by `wr_sel_i`: 0 for core, 1 for peripheral, 2 for external bus. `wr_sel_i`=3 stores nothing.
- R3: Pending fields are copied to the applied fields only at a clock edge where `bus_end_i`=1, and the result is visible from the next cycle. A write and a bus end in the same edge apply the pending value from before that write.
- R4: `mode_multi_o` is 1 exactly when at least one applied field is nonzero.
- R5: An applied core field n in the range 0..5 gives an enable in every cycle where the low n bits of the shared counter are zero, which is one pulse every 2^n cycles. The values 6 and 7 act as 5. The counter starts at 0 after reset and advances by one every cycle, modulo 32.
- R6: The peripheral and external-bus exponents are each the larger of their own saturated field and the core exponent, so neither domain pulses more often than the core.
- R7: In run state (`lp_state_o`=0), `sleep_req_i`=1 with `stby_sel_i`=0 enters sleep (`lp_state_o`=1) from the next cycle. In sleep the core enable is held low and the other two domains keep pulsing.
- R8: In sleep, `irq_i`=1 or `ext_irq_i`=1 returns the block to run from the next cycle. The applied fields are unchanged.
- R9: In run state, `sleep_req_i`=1 with `stby_sel_i`=1 enters standby (`lp_state_o`=2), where all enables are held low. `irq_i` has no effect in standby. Only `ext_irq_i`=1 returns to run, with the earlier fields still applied.
- R10: `wdt_rst_i`=1 at an edge has the same result as R1 from the next cycle: fields cleared, normal mode, run state, counter at 0. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low pin reset |
| wdt_rst_i | input | 1 | Watchdog overflow reset, synchronous, active high |
| wr_en_i | input | 1 | Ratio field write strobe |
| wr_sel_i | input | 2 | Field select: 0 core, 1 peripheral, 2 external bus |
| wr_data_i | input | 3 | Ratio exponent to write |
| bus_end_i | input | 1 | End of the current bus cycle; applies pending fields |
| sleep_req_i | input | 1 | Sleep request from the core |
| stby_sel_i | input | 1 | 0 selects sleep, 1 selects standby |
| irq_i | input | 1 | Any interrupt (wakes from sleep only) |
| ext_irq_i | input | 1 | External interrupt (wakes from sleep or standby) |
| en_core_o | output | 1 | Core and bus-master clock enable |
| en_per_o | output | 1 | Peripheral clock enable |
| en_ext_o | output | 1 | External bus clock enable |
| mode_multi_o | output | 1 | 1 in multi-clock mode |
| lp_state_o | output | 2 | 0 run, 1 sleep, 2 standby |

## Verification
The strobes are tried first with all fields at zero. They are then tried with a slow core and a peripheral field that asks for a faster rate, which separates a working clamp from a copied field. Reserved values 6 and 7 on the external field show whether saturation to divide-by-32 is in place. Writes held back for several cycles without a bus end, followed by a write in the same edge as a bus end, tell deferred application apart from immediate application and show which pending value is taken. Sleep and standby entries with each interrupt kind show which wake sources each state accepts and which enables it gates. A watchdog pulse in the middle of a run checks that it clears the state in the same way as a pin reset.

// File: rtl/crc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clock ratio controller.
package crc_pkg;
    // Low-power state encoding, also driven on lp_state_o.
    typedef enum logic [1:0] {
        LP_RUN   = 2'd0,
        LP_SLEEP = 2'd1,
        LP_STBY  = 2'd2
    } lp_state_t;
endpackage

// File: rtl/crc_ratio_regs.sv
`timescale 1ns/1ps
// Module: crc_ratio_regs
// Holds a pending and an applied ratio field for each domain. Writes land in
// the pending set. The applied set copies the pending set at the bus-cycle end.
// Assumes: synchronous active-low reset, watchdog reset has top priority.
module crc_ratio_regs #(
    parameter int SEL_W = 3,
    parameter int DOM   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wdt_rst_i,
    input  logic                      wr_en_i,
    input  logic [1:0]                wr_sel_i,
    input  logic [SEL_W-1:0]          wr_data_i,
    input  logic                      bus_end_i,
    output logic [DOM-1:0][SEL_W-1:0] act_o
);
    logic [DOM-1:0][SEL_W-1:0] pend_q;
    logic [DOM-1:0][SEL_W-1:0] act_q;

    for (genvar d = 0; d < DOM; d++) begin : g_dom
        // Pending field d: captures a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n || wdt_rst_i)
                pend_q[d] <= '0;
            else if (wr_en_i && (32'(wr_sel_i) == d))
                pend_q[d] <= wr_data_i;
        end

        // Applied field d: takes the pending value at the end of a bus cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || wdt_rst_i)
                act_q[d] <= '0;
            else if (bus_end_i)
                act_q[d] <= pend_q[d];
        end
    end

    assign act_o = act_q;

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_end_i && !wdt_rst_i) |=> $stable(act_q));
    // R10
    wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_i |=> (act_q == '0 && pend_q == '0));
endmodule

// File: rtl/crc_lp_fsm.sv
`timescale 1ns/1ps
// Module: crc_lp_fsm
// Tracks run, sleep and standby. Sleep wakes on any interrupt. Standby wakes
// only on an external interrupt. Assumes a sleep request is honoured only in run.
module crc_lp_fsm
    import crc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wdt_rst_i,
    input  logic      sleep_req_i,
    input  logic      stby_sel_i,
    input  logic      irq_i,
    input  logic      ext_irq_i,
    output lp_state_t state_o
);
    lp_state_t state_q, state_d;

    // Next-state selection for the low-power states.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_RUN:   if (sleep_req_i) state_d = stby_sel_i ? LP_STBY : LP_SLEEP;
            LP_SLEEP: if (irq_i || ext_irq_i) state_d = LP_RUN;
            LP_STBY:  if (ext_irq_i) state_d = LP_RUN;
            default:  state_d = LP_RUN;
        endcase
    end

    // State register, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wdt_rst_i) state_q <= LP_RUN;
        else                     state_q <= state_d;
    end

    assign state_o = state_q;

    // R9
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_STBY && !ext_irq_i && !wdt_rst_i) |=> state_q == LP_STBY);
    // R8
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_SLEEP && (irq_i || ext_irq_i)) |=> state_q == LP_RUN);
endmodule

// File: rtl/crc_strobe_gen.sv
`timescale 1ns/1ps
// Module: crc_strobe_gen
// One free-running counter feeds every domain. A domain pulses when the low
// bits of the counter, as many as its exponent, are all zero. Domain 0 is the
// core. The other domains are clamped to be no faster than the core.
// Assumes: fields above MAX_EXP saturate to MAX_EXP.
module crc_strobe_gen #(
    parameter int SEL_W   = 3,
    parameter int MAX_EXP = 5,
    parameter int DOM     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wdt_rst_i,
    input  logic [DOM-1:0][SEL_W-1:0] act_i,
    input  logic                      run_core_i,
    input  logic                      run_rest_i,
    output logic [DOM-1:0]            en_o
);
    localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

    logic [CNT_W-1:0]           cnt_q;
    logic [DOM-1:0][SEL_W-1:0]  sat_exp;
    logic [DOM-1:0][SEL_W-1:0]  eff_exp;
    logic [DOM-1:0]             tick;

    // Shared divider counter, restarted by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wdt_rst_i) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    for (genvar d = 0; d < DOM; d++) begin : g_dom
        logic [CNT_W-1:0] mask;
        // Saturate reserved field values to the slowest rate.
        always_comb begin
            sat_exp[d] = (act_i[d] > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : act_i[d];
        end
        if (d == 0) begin : g_core
            // The core uses its own saturated exponent.
            always_comb eff_exp[d] = sat_exp[d];
        end else begin : g_clamp
            // Never faster than the core: take the larger exponent.
            always_comb eff_exp[d] = (sat_exp[d] < sat_exp[0]) ? sat_exp[0] : sat_exp[d];
        end
        // Pulse when the masked counter bits are all zero.
        always_comb begin
            mask    = CNT_W'((33'd1 << eff_exp[d]) - 33'd1);
            tick[d] = ((cnt_q & mask) == '0);
        end
        if (d == 0) begin : g_en_core
            assign en_o[d] = tick[d] & run_core_i;
        end else begin : g_en_rest
            assign en_o[d] = tick[d] & run_rest_i;
        end
    end

    // R6
    clamp_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[1] |-> tick[0]);
    // R6
    clamp_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[DOM-1] |-> tick[0]);
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_rst_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/clk_ratio_ctrl.sv
`timescale 1ns/1ps
// Module: clk_ratio_ctrl (top)
// Generates core, peripheral and external-bus clock enables from one master
// clock. Ratio fields are written by software and applied at the bus-cycle
// end. Low-power states gate the enables.
// Assumes: all inputs are synchronous to clk, and rst_n is the pin reset.
module clk_ratio_ctrl #(
    parameter int SEL_W   = 3,
    parameter int MAX_EXP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [SEL_W-1:0] wr_data_i,
    input  logic             bus_end_i,
    input  logic             sleep_req_i,
    input  logic             stby_sel_i,
    input  logic             irq_i,
    input  logic             ext_irq_i,
    output logic             en_core_o,
    output logic             en_per_o,
    output logic             en_ext_o,
    output logic             mode_multi_o,
    output logic [1:0]       lp_state_o
);
    import crc_pkg::*;
    localparam int DOM = 3;

    logic [DOM-1:0][SEL_W-1:0] act;
    lp_state_t                 lp_state;
    logic [DOM-1:0]            en;
    logic                      run_core, run_rest;

    crc_ratio_regs #(.SEL_W(SEL_W), .DOM(DOM)) u_regs (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .bus_end_i(bus_end_i), .act_o(act)
    );

    crc_lp_fsm u_lp (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i),
        .sleep_req_i(sleep_req_i), .stby_sel_i(stby_sel_i),
        .irq_i(irq_i), .ext_irq_i(ext_irq_i), .state_o(lp_state)
    );

    // Gating: sleep stops the core only, standby stops every domain.
    always_comb begin
        run_core = (lp_state == LP_RUN);
        run_rest = (lp_state != LP_STBY);
    end

    crc_strobe_gen #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP), .DOM(DOM)) u_strobe (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i),
        .act_i(act), .run_core_i(run_core), .run_rest_i(run_rest), .en_o(en)
    );

    assign en_core_o    = en[0];
    assign en_per_o     = en[1];
    assign en_ext_o     = en[2];
    assign mode_multi_o = (act != '0);
    assign lp_state_o   = lp_state;

    // R9
    stby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state_o == 2'd2) |-> !(en_core_o || en_per_o || en_ext_o));
    // R7
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state_o == 2'd1) |-> !en_core_o);
    // R4
    normal_all_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_multi_o && lp_state_o == 2'd0) |-> (en_core_o && en_per_o && en_ext_o));
endmodule

// File: tb/clk_ratio_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared on every falling edge.
module clk_ratio_ctrl_tb;
    logic clk = 0, rst_n = 0, wdt = 0, wr_en = 0, bus_end = 0;
    logic sleep_req = 0, stby_sel = 0, irq = 0, ext_irq = 0;
    logic [1:0] wr_sel = 0;
    logic [2:0] wr_data = 0;
    logic en_core, en_per, en_ext, mode_multi;
    logic [1:0] lp_state;

    int n_chk = 0, n_err = 0;
    int m_pend[3], m_act[3], m_nact[3];
    int m_lp = 0, m_cnt = 0;
    bit m_valid = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clk_ratio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .bus_end_i(bus_end),
        .sleep_req_i(sleep_req), .stby_sel_i(stby_sel), .irq_i(irq),
        .ext_irq_i(ext_irq), .en_core_o(en_core), .en_per_o(en_per),
        .en_ext_o(en_ext), .mode_multi_o(mode_multi), .lp_state_o(lp_state)
    );

    function automatic int sat5(int v); return (v > 5) ? 5 : v; endfunction
    function automatic bit tick(int c, int e); return (c % (1 << e)) == 0; endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || wdt) begin
            for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_act[i] = 0; end
            m_lp = 0; m_cnt = 0; m_valid = 1;
        end else begin
            for (int i = 0; i < 3; i++) m_nact[i] = bus_end ? m_pend[i] : m_act[i];
            if (wr_en && wr_sel != 2'd3) m_pend[wr_sel] = int'(wr_data);
            for (int i = 0; i < 3; i++) m_act[i] = m_nact[i];
            case (m_lp)
                0: if (sleep_req) m_lp = stby_sel ? 2 : 1;
                1: if (irq || ext_irq) m_lp = 0;
                default: if (ext_irq) m_lp = 0;
            endcase
            m_cnt = (m_cnt + 1) % 32;
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            int ec, ep, ee;
            ec = sat5(m_act[0]);
            ep = (sat5(m_act[1]) < ec) ? ec : sat5(m_act[1]);
            ee = (sat5(m_act[2]) < ec) ? ec : sat5(m_act[2]);
            chk("R5 core strobe", 8'(en_core), 8'((m_lp == 0) && tick(m_cnt, ec)));
            chk("R6 periph strobe", 8'(en_per), 8'((m_lp != 2) && tick(m_cnt, ep)));
            chk("R6 ext strobe", 8'(en_ext), 8'((m_lp != 2) && tick(m_cnt, ee)));
            chk("R4 mode", 8'(mode_multi), 8'((m_act[0] | m_act[1] | m_act[2]) != 0));
            chk("R7 lp state", 8'(lp_state), 8'(m_lp));
        end
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic wr(logic [1:0] s, logic [2:0] d, logic be);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d; bus_end = be;
        @(negedge clk);
        wr_en = 0; bus_end = 0;
    endtask
    task automatic pulse_bus_end;
        @(negedge clk); bus_end = 1; @(negedge clk); bus_end = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3); rst_n = 1;
        // R1 reset state
        chk("R1 mode after reset", 8'(mode_multi), 8'd0);
        chk("R1 lp after reset", 8'(lp_state), 8'd0);
        chk("R1 all enables", 8'({en_core, en_per, en_ext}), 8'd7);
        cyc(5);
        // R2 select 3 stores nothing
        wr(2'd3, 3'd4, 1'b0); pulse_bus_end;
        chk("R2 select 3 ignored", 8'(mode_multi), 8'd0);
        // R3 deferred until bus end
        wr(2'd0, 3'd1, 1'b0); cyc(4);
        chk("R3 no apply before bus end", 8'(mode_multi), 8'd1 - 8'd1);
        pulse_bus_end;
        chk("R3 applied at bus end", 8'(mode_multi), 8'd1);
        // R6 clamp: core 2, periph 0, ext reserved 7
        wr(2'd0, 3'd2, 1'b0); wr(2'd1, 3'd0, 1'b0); wr(2'd2, 3'd7, 1'b0);
        pulse_bus_end; cyc(70);
        // R3 write with bus end in the same edge uses old pending
        wr(2'd2, 3'd1, 1'b1); cyc(40);
        pulse_bus_end; cyc(40);
        wr(2'd0, 3'd6, 1'b1); pulse_bus_end; cyc(70);
        // R7 sleep then R8 wake by irq
        @(negedge clk); sleep_req = 1; stby_sel = 0;
        @(negedge clk); sleep_req = 0;
        chk("R7 in sleep", 8'(lp_state), 8'd1);
        chk("R7 core gated", 8'(en_core), 8'd0);
        cyc(40);
        @(negedge clk); irq = 1; @(negedge clk); irq = 0;
        chk("R8 woke by irq", 8'(lp_state), 8'd0);
        chk("R8 fields kept", 8'(mode_multi), 8'd1);
        cyc(20);
        // R9 standby: irq ignored, ext_irq wakes
        @(negedge clk); sleep_req = 1; stby_sel = 1;
        @(negedge clk); sleep_req = 0; stby_sel = 0;
        chk("R9 in standby", 8'(lp_state), 8'd2);
        cyc(10);
        @(negedge clk); irq = 1; @(negedge clk); irq = 0;
        chk("R9 irq ignored", 8'(lp_state), 8'd2);
        chk("R9 all gated", 8'({en_core, en_per, en_ext}), 8'd0);
        cyc(40);
        @(negedge clk); ext_irq = 1; @(negedge clk); ext_irq = 0;
        chk("R9 woke by ext irq", 8'(lp_state), 8'd0);
        chk("R9 fields restored", 8'(mode_multi), 8'd1);
        cyc(30);
        // R8 sleep woken by ext_irq
        @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
        cyc(5);
        @(negedge clk); ext_irq = 1; @(negedge clk); ext_irq = 0;
        chk("R8 woke by ext irq", 8'(lp_state), 8'd0);
        // R10 watchdog reset mid-run, with sleep
        wr(2'd1, 3'd3, 1'b1); cyc(7);
        @(negedge clk); sleep_req = 1;
        @(negedge clk); sleep_req = 0; wdt = 1;
        @(negedge clk); wdt = 0;
        chk("R10 mode cleared", 8'(mode_multi), 8'd0);
        chk("R10 run state", 8'(lp_state), 8'd0);
        chk("R10 all enables", 8'({en_core, en_per, en_ext}), 8'd7);
        pulse_bus_end;
        chk("R10 pending cleared", 8'(mode_multi), 8'd0);
        // R4 back to normal mode by clearing all fields
        wr(2'd0, 3'd3, 1'b0); wr(2'd2, 3'd4, 1'b1); pulse_bus_end; cyc(40);
        wr(2'd0, 3'd0, 1'b0); wr(2'd2, 3'd0, 1'b0); cyc(3);
        chk("R4 still multi before bus end", 8'(mode_multi), 8'd1);
        pulse_bus_end;
        chk("R4 normal after clear", 8'(mode_multi), 8'd0);
        cyc(10);
        // R1 pin reset during multi mode
        wr(2'd0, 3'd5, 1'b1); pulse_bus_end; cyc(9);
        @(negedge clk); rst_n = 0; cyc(2); rst_n = 1;
        chk("R1 pin reset clears", 8'(mode_multi), 8'd0);
        cyc(10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule